// File: doc/BRIEF.md
# Asynchronous SRAM Port Controller

This block sits between a clocked host and an external asynchronous static RAM of 2^ADDR_W words by DATA_W bits that uses one shared data bus and two active-low strobes: a write strobe and an output strobe. The host issues one request at a time with a valid flag, a write flag, an address and write data. The controller converts each request into a timed pin sequence. For a write, the address and data settle first, then the write strobe pulses, then a hold period follows. For a read, the output strobe stays low until the access time has passed, and the result is captured at the end of that period.

Every phase length is a parameter counted in clock cycles. The shared bus appears at the pins as a drive value, a drive enable and a sampled input, so a pad ring or test model can build the tri-state buffer. The controller turns the driver on only while it owns the bus for a write. It never lets both strobes be low together. After every read it inserts a quiet turnaround period before the driver can come on again.

Read results come back through a single-cycle valid pulse. `req_ready` is high only in the idle phase, and only a request seen while ready is high starts a transaction.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it: `req_ready` = 1, `mem_we_n` = 1, `mem_oe_n` = 1, `mem_dq_oe` = 0, `rsp_valid` = 0.
- R2: `mem_we_n` and `mem_oe_n` are never low in the same cycle.
- R3: A write drives its address and data with `mem_dq_oe` = 1 and both strobes high for exactly SETUP_CYC cycles. `mem_we_n` is then low for exactly PULSE_CYC cycles. Address, data and drive enable then stay unchanged for exactly HOLD_CYC more cycles with `mem_we_n` high. Address and data do not change at any point in the sequence.
- R4: `mem_dq_oe` is 0 in every cycle in which `mem_oe_n` is 0.
- R5: A read holds `mem_oe_n` low for exactly ACCESS_CYC cycles with a constant address. `mem_dq_i` is sampled at the clock edge that ends the last of those cycles.
- R6: `rsp_valid` is high for exactly one cycle, the cycle right after the last read-access cycle, and `rsp_rdata` carries the sampled word in that cycle. `rsp_valid` stays 0 throughout a write.
- R7: After a read, both strobes stay high and `mem_dq_oe` stays 0 for at least TURN_CYC cycles (TURN_CYC ≥ 1) before any write can drive the bus. `req_ready` is 0 during those cycles.
- R8: A request is taken only in a cycle where both `req_valid` and `req_ready` are 1. A request presented while `req_ready` is 0 and withdrawn before ready returns has no effect on the memory.
- R9: With acceptance in cycle 0, a write makes `req_ready` high again in cycle SETUP_CYC+PULSE_CYC+HOLD_CYC+1, and a read makes it high again in cycle ACCESS_CYC+TURN_CYC+1. A new request can be taken in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Controller idle, request accepted this cycle if valid |
| rsp_valid | output | 1 | One-cycle read result strobe |
| rsp_rdata | output | DATA_W | Read result |
| mem_addr | output | ADDR_W | Address pins of the memory |
| mem_dq_o | output | DATA_W | Value driven onto the shared data bus |
| mem_dq_oe | output | 1 | Drive enable of the bus buffer, 1 = drive |
| mem_dq_i | input | DATA_W | Value seen on the shared data bus |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output strobe, active low |

## Verification
Two things can land in the same cycle. One is the end of a read (the output strobe releasing, the result pulse and the turnaround). The other is the next host request arriving the moment ready returns. The bench provokes this by issuing a write directly after a read, and by presenting a request while the controller is mid-write. A pin-level memory model counts the quiet cycles between the output strobe rising and the driver turning on. It also returns undefined data until the access time has elapsed, so a capture that is early or late shows up as a wrong word. The model also proves that a request withdrawn while busy left the addressed word unchanged on a later read.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_WSETUP  = 3'd1,
        PH_WPULSE  = 3'd2,
        PH_WHOLD   = 3'd3,
        PH_RACCESS = 3'd4,
        PH_RTURN   = 3'd5
    } phase_e;

    typedef struct packed {
        logic we_n;
        logic oe_n;
        logic drive;
    } strobe_t;

    function automatic strobe_t strobes_for(phase_e ph);
        strobe_t s;
        s = '{we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};
        case (ph)
            PH_WSETUP:  s.drive = 1'b1;
            PH_WPULSE:  begin s.drive = 1'b1; s.we_n = 1'b0; end
            PH_WHOLD:   s.drive = 1'b1;
            PH_RACCESS: s.oe_n = 1'b0;
            default:    s = '{we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};
        endcase
        return s;
    endfunction

    function automatic int max_of(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign last = (cnt == '0);
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
    import sram_ctl_pkg::*;
#(
    parameter int SETUP_CYC  = 1,
    parameter int PULSE_CYC  = 2,
    parameter int HOLD_CYC   = 1,
    parameter int ACCESS_CYC = 2,
    parameter int TURN_CYC   = 1,
    parameter int CNT_W      = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             timer_last,
    output phase_e           cur_ph,
    output phase_e           nxt_ph,
    output logic             ready,
    output logic             accept,
    output logic             load,
    output logic [CNT_W-1:0] load_val
);
    localparam logic [CNT_W-1:0] D_SETUP  = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] D_PULSE  = CNT_W'(PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] D_HOLD   = CNT_W'(HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] D_ACCESS = CNT_W'(ACCESS_CYC - 1);
    localparam logic [CNT_W-1:0] D_TURN   = CNT_W'(TURN_CYC - 1);

    always_ff @(posedge clk) begin
        if (rst) cur_ph <= PH_IDLE;
        else     cur_ph <= nxt_ph;
    end

    assign ready  = (cur_ph == PH_IDLE);
    assign accept = ready && req_valid;

    always_comb begin
        nxt_ph = cur_ph;
        case (cur_ph)
            PH_IDLE:    if (accept) nxt_ph = req_write ? PH_WSETUP : PH_RACCESS;
            PH_WSETUP:  if (timer_last) nxt_ph = PH_WPULSE;
            PH_WPULSE:  if (timer_last) nxt_ph = PH_WHOLD;
            PH_WHOLD:   if (timer_last) nxt_ph = PH_IDLE;
            PH_RACCESS: if (timer_last) nxt_ph = PH_RTURN;
            PH_RTURN:   if (timer_last) nxt_ph = PH_IDLE;
            default:    nxt_ph = PH_IDLE;
        endcase
    end

    assign load = (nxt_ph != cur_ph);

    always_comb begin
        case (nxt_ph)
            PH_WSETUP:  load_val = D_SETUP;
            PH_WPULSE:  load_val = D_PULSE;
            PH_WHOLD:   load_val = D_HOLD;
            PH_RACCESS: load_val = D_ACCESS;
            PH_RTURN:   load_val = D_TURN;
            default:    load_val = '0;
        endcase
    end

    // R3: the strobe phase is only ever reached from setup
    p_pulse_after_setup_r3: assert property (@(posedge clk) disable iff (rst)
        (cur_ph == PH_WPULSE) |-> ($past(cur_ph) == PH_WSETUP || $past(cur_ph) == PH_WPULSE));

    // R7: every read is followed by a turnaround phase
    p_read_then_turn_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(cur_ph) == PH_RACCESS && cur_ph != PH_RACCESS) |-> (cur_ph == PH_RTURN));
endmodule

// File: rtl/sram_bus_path.sv
module sram_bus_path
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  phase_e            cur_ph,
    input  phase_e            nxt_ph,
    input  logic              timer_last,
    input  logic [DATA_W-1:0] dq_i,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_oe,
    output logic              we_n,
    output logic              oe_n,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    strobe_t want;
    logic    we_n_d, oe_n_d, drv_d, sample;

    always_comb begin
        want   = strobes_for(nxt_ph);
        // guards: output strobe forced off while writing, driver off while reading
        we_n_d = want.we_n;
        oe_n_d = want.oe_n | ~want.we_n;
        drv_d  = want.drive & oe_n_d;
    end

    assign sample = (cur_ph == PH_RACCESS) && timer_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_n      <= 1'b1;
            oe_n      <= 1'b1;
            dq_oe     <= 1'b0;
            rsp_valid <= 1'b0;
            mem_addr  <= '0;
            dq_o      <= '0;
            rsp_rdata <= '0;
        end else begin
            we_n      <= we_n_d;
            oe_n      <= oe_n_d;
            dq_oe     <= drv_d;
            rsp_valid <= sample;
            if (accept) begin
                mem_addr <= req_addr;
                dq_o     <= req_wdata;
            end
            if (sample) rsp_rdata <= dq_i;
        end
    end

    // R2
    p_strobe_excl_r2: assert property (@(posedge clk) disable iff (rst)
        !(!we_n && !oe_n));
    // R4
    p_no_drive_in_read_r4: assert property (@(posedge clk) disable iff (rst)
        !oe_n |-> !dq_oe);
    // R3: write strobe only with the bus driven
    p_we_under_drive_r3: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> dq_oe);
    // R3: address and data frozen while driving
    p_write_stable_r3: assert property (@(posedge clk) disable iff (rst)
        (dq_oe && $past(dq_oe)) |-> ($stable(dq_o) && $stable(mem_addr)));
    // R5
    p_read_addr_stable_r5: assert property (@(posedge clk) disable iff (rst)
        (!oe_n && $past(!oe_n)) |-> $stable(mem_addr));
    // R6
    p_rsp_single_r6: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);
    p_rsp_after_read_r6: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ($past(!oe_n) && oe_n));
    // R7
    p_turn_gap_r7: assert property (@(posedge clk) disable iff (rst)
        $past(!oe_n) |-> !dq_oe);
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int DATA_W     = 16,
    parameter int SETUP_CYC  = 1,
    parameter int PULSE_CYC  = 2,
    parameter int HOLD_CYC   = 1,
    parameter int ACCESS_CYC = 2,
    parameter int TURN_CYC   = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i,
    output logic              mem_we_n,
    output logic              mem_oe_n
);
    localparam int MAX_W   = max_of(max_of(SETUP_CYC, PULSE_CYC), HOLD_CYC);
    localparam int MAX_R   = max_of(ACCESS_CYC, TURN_CYC);
    localparam int MAX_DUR = max_of(MAX_W, MAX_R);
    localparam int CNT_W   = max_of($clog2(MAX_DUR + 1), 1);

    phase_e           cur_ph, nxt_ph;
    logic             accept, load, timer_last;
    logic [CNT_W-1:0] load_val;

    sram_seq_fsm #(
        .SETUP_CYC (SETUP_CYC),
        .PULSE_CYC (PULSE_CYC),
        .HOLD_CYC  (HOLD_CYC),
        .ACCESS_CYC(ACCESS_CYC),
        .TURN_CYC  (TURN_CYC),
        .CNT_W     (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .timer_last(timer_last),
        .cur_ph    (cur_ph),
        .nxt_ph    (nxt_ph),
        .ready     (req_ready),
        .accept    (accept),
        .load      (load),
        .load_val  (load_val)
    );

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .load_val(load_val),
        .last    (timer_last)
    );

    sram_bus_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_path (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .cur_ph    (cur_ph),
        .nxt_ph    (nxt_ph),
        .timer_last(timer_last),
        .dq_i      (mem_dq_i),
        .mem_addr  (mem_addr),
        .dq_o      (mem_dq_o),
        .dq_oe     (mem_dq_oe),
        .we_n      (mem_we_n),
        .oe_n      (mem_oe_n),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    // R8: the address register never moves while the controller is busy
    p_busy_addr_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !req_ready |=> $stable(mem_addr));
    // R8: idle means a quiet bus
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (mem_we_n && mem_oe_n && !mem_dq_oe));
endmodule

// File: tb/sim_sram_async_ctrl.sv
module sim_sram_async_ctrl;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int AW  = 6;
    localparam int DW  = 16;
    localparam int SU  = 2;
    localparam int PW  = 3;
    localparam int HO  = 1;
    localparam int ACC = 3;
    localparam int TRN = 1;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr  = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, rsp_valid, mem_dq_oe, mem_we_n, mem_oe_n;
    logic [DW-1:0] rsp_rdata, mem_dq_o, mem_dq_i;
    logic [AW-1:0] mem_addr;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [DW-1:0] model [DEPTH];
    logic [DW-1:0] shadow [DEPTH];

    always #2.5 clk = ~clk;

    sram_async_ctrl #(
        .ADDR_W(AW), .DATA_W(DW), .SETUP_CYC(SU), .PULSE_CYC(PW),
        .HOLD_CYC(HO), .ACCESS_CYC(ACC), .TURN_CYC(TRN)
    ) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // ---------------- pin-level memory model and timing monitor ----------------
    int            oe_age = 0;
    int            mon_ph = 0;
    int            s_cnt = 0, p_cnt = 0, h_cnt = 0;
    logic [AW-1:0] w_addr, r_addr;
    logic [DW-1:0] w_data;
    int            gap = 0;
    bit            armed = 1'b0;

    assign mem_dq_i = (!mem_oe_n && oe_age >= ACC) ? model[mem_addr] : 16'hBAD0;

    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R2 strobes both low", {31'd0, (!mem_we_n && !mem_oe_n)}, 32'd0);
            if (!mem_oe_n && mem_dq_oe) check("R4 drive during read", 32'd1, 32'd0);
            // read access age and address stability
            if (!mem_oe_n) begin
                if (oe_age == 0) r_addr = mem_addr;
                else if (mem_addr != r_addr) check("R5 read address moved", {26'd0, mem_addr}, {26'd0, r_addr});
                oe_age++;
            end else begin
                oe_age = 0;
            end
            // turnaround after read
            if (!mem_oe_n) begin
                gap = 0; armed = 1'b1;
            end else if (armed) begin
                if (mem_dq_oe) begin
                    check("R7 quiet cycles before drive", {31'd0, gap >= TRN}, 32'd1);
                    armed = 1'b0;
                end else begin
                    gap++;
                end
            end
            // write sequence
            if (mon_ph != 0 && mem_dq_oe && (mem_addr != w_addr || mem_dq_o != w_data))
                check("R3 address/data moved during write", 32'd1, 32'd0);
            case (mon_ph)
                0: if (mem_dq_oe) begin
                       if (!mem_we_n) check("R3 strobe without setup", 32'd1, 32'd0);
                       mon_ph = 1; s_cnt = 1; w_addr = mem_addr; w_data = mem_dq_o;
                   end
                1: if (!mem_dq_oe) begin
                       check("R3 drive dropped in setup", 32'd1, 32'd0);
                       mon_ph = 0;
                   end else if (!mem_we_n) begin
                       check("R3 setup cycles", s_cnt, SU);
                       mon_ph = 2; p_cnt = 1;
                   end else s_cnt++;
                2: if (mem_we_n) begin
                       check("R3 strobe cycles", p_cnt, PW);
                       model[w_addr] = w_data;
                       if (!mem_dq_oe) begin
                           check("R3 hold cycles", 32'd0, HO);
                           mon_ph = 0;
                       end else begin
                           mon_ph = 3; h_cnt = 1;
                       end
                   end else p_cnt++;
                default: if (!mem_dq_oe) begin
                       check("R3 hold cycles", h_cnt, HO);
                       mon_ph = 0;
                   end else h_cnt++;
            endcase
        end
    end

    // ---------------- scenario tasks ----------------
    task automatic wait_ready();
        while (!req_ready) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 ready in reset", {31'd0, req_ready}, 32'd1);
        check("R1 we_n in reset", {31'd0, mem_we_n}, 32'd1);
        check("R1 oe_n in reset", {31'd0, mem_oe_n}, 32'd1);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 ready after reset", {31'd0, req_ready}, 32'd1);
        check("R1 drive off after reset", {31'd0, mem_dq_oe}, 32'd0);
        check("R1 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
        check("R1 strobes idle after reset", {30'd0, mem_we_n, mem_oe_n}, 32'd3);
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        int last_k;
        wait_ready();
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        shadow[a] = d;
        last_k = SU + PW + HO + 1;
        for (int k = 1; k <= last_k; k++) begin
            @(negedge clk);
            if (k == 1) req_valid = 1'b0;
            check("R6 no response on write", {31'd0, rsp_valid}, 32'd0);
            if (k == last_k - 1) check("R9 busy through hold", {31'd0, req_ready}, 32'd0);
            if (k == last_k)     check("R9 ready after write", {31'd0, req_ready}, 32'd1);
        end
    endtask

    task automatic do_read(input logic [AW-1:0] a);
        int last_k;
        wait_ready();
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        last_k = ACC + TRN + 1;
        if (last_k < ACC + 2) last_k = ACC + 2;
        for (int k = 1; k <= last_k; k++) begin
            @(negedge clk);
            if (k == 1) req_valid = 1'b0;
            if (k <= ACC) begin
                check("R6 no early response", {31'd0, rsp_valid}, 32'd0);
                check("R5 output strobe low", {31'd0, mem_oe_n}, 32'd0);
            end
            if (k == ACC + 1) begin
                check("R6 response pulse", {31'd0, rsp_valid}, 32'd1);
                check("R5 read data", {16'd0, rsp_rdata}, {16'd0, shadow[a]});
                check("R7 busy in turnaround", {31'd0, req_ready}, 32'd0);
            end
            if (k == ACC + 2) check("R6 pulse single", {31'd0, rsp_valid}, 32'd0);
            if (k == ACC + TRN + 1) check("R9 ready after read", {31'd0, req_ready}, 32'd1);
        end
    endtask

    task automatic t_patterns();
        do_write(6'd0, 16'h0000);
        do_write(6'd63, 16'hFFFF);
        do_write(6'd21, 16'hA5A5);
        do_read(6'd0);
        do_read(6'd63);
        do_read(6'd21);
        do_read(6'd40);
    endtask

    task automatic t_busy_request();
        wait_ready();
        req_valid = 1'b1; req_write = 1'b1; req_addr = 6'd5; req_wdata = 16'h1111;
        shadow[5] = 16'h1111;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        check("R8 ready low while busy", {31'd0, req_ready}, 32'd0);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 6'd7; req_wdata = 16'h7777;
        @(negedge clk);
        req_valid = 1'b0;
        do_read(6'd7);
        do_read(6'd5);
    endtask

    task automatic t_read_then_write();
        do_read(6'd21);
        do_write(6'd22, 16'h3C3C);
        do_write(6'd23, 16'hC3C3);
        do_read(6'd22);
        do_read(6'd23);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            model[i]  = 16'h4000 + 16'(i);
            shadow[i] = 16'h4000 + 16'(i);
        end
        @(negedge clk);
        t_reset();
        t_patterns();
        t_busy_request();
        t_read_then_write();
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule